// File: doc/BRIEF.md
# Interval Timer with Reload Latch

This block is a 16-bit down-counter with a 16-bit reload latch. Software programs it one byte at a time through four register slots. Each enabled tick of the timer-rate strobe lowers the count by one. The count passes through zero and then all-ones, after which the latch value is loaded again, so each period lasts latch + 2 ticks.

When the two mode bits (bits 7:6 of the auxiliary control register, supplied on `mode_i`) select continuous operation, the block emits a one-cycle event each time the count reaches zero. The event sets the timer flag, which is held in an external interrupt controller. The block also emits a one-cycle clear pulse whenever a register access should clear that flag. The live count can be read back one byte at a time.

Top module: `ivl_timer`

## Requirements
- R1: After reset the count and the latch are both 0xFFFF. `evt_o` and `flag_clr_o` are low, and reading slots 2 and 3 returns 0xFF.
- R2: Each clock with `tick_i` high and no counter load lowers the count by one on that edge. Without a tick or a load, the count holds.
- R3: A tick taken at count 0xFFFF loads the latch value, so a period is latch + 2 ticks. A latch byte written on the same edge is already part of the value loaded.
- R4: `evt_o` is high for exactly the one cycle in which a tick has brought the count to zero, and only when `mode_i` was 2'b01 at that tick. A latch of zero gives an event every second tick.
- R5: With `mode_i` at 2'b00, 2'b10 or 2'b11, no event is produced, but counting and reloading carry on unchanged.
- R6: A write to slot 0 or slot 2 replaces only the latch low byte. The count does not change and no clear pulse follows.
- R7: A write to slot 1 replaces the latch high byte and loads the whole new latch into the count on the same edge. `flag_clr_o` pulses in the next cycle.
- R8: A write to slot 3 replaces the latch high byte and pulses `flag_clr_o` in the next cycle, but it leaves the count alone.
- R9: `rd_data_o` returns, for slots 0, 1, 2 and 3 in that order: count bits 7:0, count bits 15:8, latch bits 7:0 and latch bits 15:8. A read strobe (`rd_en_i`) on slot 0 pulses `flag_clr_o` in the next cycle; reads of the other slots do not.
- R10: A slot 1 write takes priority over a tick on the same edge. The count takes the latch value, it is not decremented, and no event is produced, even if the tick would have reached zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Count enable at the timer rate |
| mode_i | input | 2 | Auxiliary control bits 7:6; 2'b01 selects continuous events |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe (drives read side effects) |
| addr_i | input | 2 | Register slot select |
| wr_data_i | input | 8 | Write data byte |
| rd_data_o | output | 8 | Read data byte for the selected slot |
| count_o | output | 16 | Live count |
| evt_o | output | 1 | One-cycle zero-reached event |
| flag_clr_o | output | 1 | One-cycle request to clear the timer flag |

## Verification
Two pairs of functions can fall on the same edge.

The first pair is a tick that would end a count at one and a slot 1 counter load. The bench lets the count run down to one, then raises the tick and the slot 1 write in the same cycle. It expects the new latch value in the count, no event and a clear pulse.

The second pair is the all-ones reload tick and a latch low write. The bench runs the count to 0xFFFF, then writes slot 2 together with the tick. It judges the case by whether the freshly written byte is the value that appears in the count.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    localparam int unsigned TMR_BYTE_W = 8;
    localparam int unsigned TMR_MODE_W = 2;
    localparam logic [TMR_MODE_W-1:0] TMR_MODE_CONT = 2'b01;

    typedef enum logic [1:0] {
        SLOT_CNT_LO = 2'd0,
        SLOT_CNT_HI = 2'd1,
        SLOT_LAT_LO = 2'd2,
        SLOT_LAT_HI = 2'd3
    } slot_e;

endpackage

// File: rtl/tmr_regs.sv
module tmr_regs
    import tmr_pkg::*;
#(
    parameter int unsigned BYTE_W = TMR_BYTE_W
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en_i,
    input  logic                  rd_en_i,
    input  logic [1:0]            addr_i,
    input  logic [BYTE_W-1:0]     wr_data_i,
    output logic [2*BYTE_W-1:0]   latch_q_o,
    output logic [2*BYTE_W-1:0]   latch_d_o,
    output logic                  load_o,
    output logic                  clr_o
);
    localparam int unsigned CNT_W = 2 * BYTE_W;

    typedef struct packed {
        logic [CNT_W-1:0] latch;
        logic             clr;
    } regs_st_t;

    regs_st_t st_d, st_q;
    logic     load_d;

    always_comb begin
        st_d     = st_q;
        st_d.clr = 1'b0;
        load_d   = 1'b0;
        if (wr_en_i) begin
            case (slot_e'(addr_i))
                SLOT_CNT_LO, SLOT_LAT_LO: begin
                    st_d.latch[BYTE_W-1:0] = wr_data_i;
                end
                SLOT_CNT_HI: begin
                    st_d.latch[CNT_W-1:BYTE_W] = wr_data_i;
                    st_d.clr = 1'b1;
                    load_d   = 1'b1;
                end
                SLOT_LAT_HI: begin
                    st_d.latch[CNT_W-1:BYTE_W] = wr_data_i;
                    st_d.clr = 1'b1;
                end
                default: ;
            endcase
        end
        if (rd_en_i && (slot_e'(addr_i) == SLOT_CNT_LO)) begin
            st_d.clr = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.latch <= '1;
            st_q.clr   <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign latch_q_o = st_q.latch;
    assign latch_d_o = st_d.latch;
    assign load_o    = load_d;
    assign clr_o     = st_q.clr;

endmodule

// File: rtl/tmr_core.sv
module tmr_core #(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             load_i,
    input  logic [CNT_W-1:0] latch_i,
    output logic [CNT_W-1:0] count_o,
    output logic             hit_o
);
    typedef struct packed {
        logic [CNT_W-1:0] count;
    } core_st_t;

    core_st_t st_d, st_q;
    logic     hit_d;

    always_comb begin
        st_d  = st_q;
        hit_d = 1'b0;
        if (load_i) begin
            st_d.count = latch_i;
        end else if (tick_i) begin
            if (st_q.count == '1) begin
                st_d.count = latch_i;
            end else begin
                st_d.count = st_q.count - CNT_W'(1);
            end
            hit_d = (st_d.count == '0);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.count <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    assign count_o = st_q.count;
    assign hit_o   = hit_d;

endmodule

// File: rtl/tmr_evt.sv
module tmr_evt #(
    parameter int unsigned          MODE_W    = 2,
    parameter logic [MODE_W-1:0]    MODE_CONT = 2'b01
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hit_i,
    input  logic [MODE_W-1:0] mode_i,
    output logic              evt_o
);
    typedef struct packed {
        logic evt;
    } evt_st_t;

    evt_st_t st_d, st_q;

    always_comb begin
        st_d.evt = hit_i && (mode_i == MODE_CONT);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.evt <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign evt_o = st_q.evt;

endmodule

// File: rtl/ivl_timer.sv
module ivl_timer
    import tmr_pkg::*;
#(
    parameter int unsigned                BYTE_W    = TMR_BYTE_W,
    parameter int unsigned                MODE_W    = TMR_MODE_W,
    parameter logic [TMR_MODE_W-1:0]      MODE_CONT = TMR_MODE_CONT
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  tick_i,
    input  logic [MODE_W-1:0]     mode_i,
    input  logic                  wr_en_i,
    input  logic                  rd_en_i,
    input  logic [1:0]            addr_i,
    input  logic [BYTE_W-1:0]     wr_data_i,
    output logic [BYTE_W-1:0]     rd_data_o,
    output logic [2*BYTE_W-1:0]   count_o,
    output logic                  evt_o,
    output logic                  flag_clr_o
);
    localparam int unsigned CNT_W = 2 * BYTE_W;

    logic [CNT_W-1:0] latch_q;
    logic [CNT_W-1:0] latch_d;
    logic             load;
    logic             hit;

    tmr_regs #(.BYTE_W(BYTE_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (wr_en_i),
        .rd_en_i   (rd_en_i),
        .addr_i    (addr_i),
        .wr_data_i (wr_data_i),
        .latch_q_o (latch_q),
        .latch_d_o (latch_d),
        .load_o    (load),
        .clr_o     (flag_clr_o)
    );

    tmr_core #(.CNT_W(CNT_W)) u_core (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_i  (tick_i),
        .load_i  (load),
        .latch_i (latch_d),
        .count_o (count_o),
        .hit_o   (hit)
    );

    tmr_evt #(.MODE_W(MODE_W), .MODE_CONT(MODE_CONT)) u_evt (
        .clk    (clk),
        .rst_n  (rst_n),
        .hit_i  (hit),
        .mode_i (mode_i),
        .evt_o  (evt_o)
    );

    always_comb begin
        case (slot_e'(addr_i))
            SLOT_CNT_LO: rd_data_o = count_o[BYTE_W-1:0];
            SLOT_CNT_HI: rd_data_o = count_o[CNT_W-1:BYTE_W];
            SLOT_LAT_LO: rd_data_o = latch_q[BYTE_W-1:0];
            SLOT_LAT_HI: rd_data_o = latch_q[CNT_W-1:BYTE_W];
            default:     rd_data_o = '0;
        endcase
    end

endmodule

// File: rtl/ivl_timer_chk.sv
module ivl_timer_chk #(
    parameter int unsigned          CNT_W     = 16,
    parameter int unsigned          MODE_W    = 2,
    parameter logic [MODE_W-1:0]    MODE_CONT = 2'b01
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tick_i,
    input logic [MODE_W-1:0] mode_i,
    input logic              wr_en_i,
    input logic              rd_en_i,
    input logic [1:0]        addr_i,
    input logic [CNT_W-1:0]  count_o,
    input logic [CNT_W-1:0]  latch_q,
    input logic              evt_o,
    input logic              flag_clr_o
);
    logic ld;
    assign ld = wr_en_i && (addr_i == 2'd1);

    assert_load_count_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ld |=> (count_o == latch_q) && flag_clr_o);

    assert_decrement_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && !ld && count_o != '1) |=> count_o == $past(count_o) - CNT_W'(1));

    assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_i && !ld) |=> $stable(count_o));

    assert_reload_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && !ld && count_o == '1) |=> count_o == latch_q);

    assert_evt_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        evt_o |-> count_o == '0);

    assert_evt_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
        evt_o |=> !evt_o);

    assert_evt_mode_R5: assert property (@(posedge clk) disable iff (!rst_n)
        evt_o |-> $past(mode_i) == MODE_CONT);

    assert_rd_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en_i && addr_i == 2'd0) |=> flag_clr_o);

    assert_hi_latch_keep_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && addr_i == 2'd3 && !tick_i) |=> $stable(count_o) && flag_clr_o);

endmodule

bind ivl_timer ivl_timer_chk #(
    .CNT_W     (2 * BYTE_W),
    .MODE_W    (MODE_W),
    .MODE_CONT (MODE_CONT)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick_i     (tick_i),
    .mode_i     (mode_i),
    .wr_en_i    (wr_en_i),
    .rd_en_i    (rd_en_i),
    .addr_i     (addr_i),
    .count_o    (count_o),
    .latch_q    (latch_q),
    .evt_o      (evt_o),
    .flag_clr_o (flag_clr_o)
);

// File: tb/test_ivl_timer.sv
`timescale 1ns/1ps
module test_ivl_timer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic [1:0]  mode = 2'b01;
    logic        wr = 1'b0;
    logic        rd = 1'b0;
    logic [1:0]  addr = 2'd0;
    logic [7:0]  wdata = 8'd0;
    logic [7:0]  rdata;
    logic [15:0] count;
    logic        evt;
    logic        clr;

    int n_chk = 0;
    int n_err = 0;

    always #2.5 clk = ~clk;

    ivl_timer i_ivl_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_i     (tick),
        .mode_i     (mode),
        .wr_en_i    (wr),
        .rd_en_i    (rd),
        .addr_i     (addr),
        .wr_data_i  (wdata),
        .rd_data_o  (rdata),
        .count_o    (count),
        .evt_o      (evt),
        .flag_clr_o (clr)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step(input logic t, input logic w, input logic r,
                        input logic [1:0] a, input logic [7:0] d);
        tick = t; wr = w; rd = r; addr = a; wdata = d;
        @(posedge clk);
        #1;
        tick = 1'b0; wr = 1'b0; rd = 1'b0;
    endtask

    task automatic peek(input logic [1:0] a, output logic [7:0] v);
        addr = a;
        #1;
        v = rdata;
    endtask

    task automatic run_ticks(input int n, output int events);
        events = 0;
        for (int i = 0; i < n; i++) begin
            step(1'b1, 1'b0, 1'b0, 2'd0, 8'd0);
            if (evt) events++;
        end
    endtask

    task automatic load5();
        step(1'b0, 1'b1, 1'b0, 2'd2, 8'h05);
        step(1'b0, 1'b1, 1'b0, 2'd1, 8'h00);
    endtask

    task automatic t_reset();
        logic [7:0] v;
        chk("R1 count", count, 16'hFFFF);
        chk("R1 evt", evt, 1'b0);
        chk("R1 clr", clr, 1'b0);
        peek(2'd2, v); chk("R1 latch lo", v, 8'hFF);
        peek(2'd3, v); chk("R1 latch hi", v, 8'hFF);
    endtask

    task automatic t_period();
        int e;
        mode = 2'b01;
        step(1'b0, 1'b1, 1'b0, 2'd2, 8'h05);
        chk("R6 count kept", count, 16'hFFFF);
        chk("R6 no clr", clr, 1'b0);
        step(1'b0, 1'b1, 1'b0, 2'd1, 8'h00);
        chk("R7 load", count, 16'h0005);
        chk("R7 clr", clr, 1'b1);
        step(1'b0, 1'b0, 1'b0, 2'd0, 8'h00);
        chk("R2 hold", count, 16'h0005);
        chk("R7 clr single", clr, 1'b0);
        for (int i = 1; i <= 7; i++) begin
            step(1'b1, 1'b0, 1'b0, 2'd0, 8'h00);
            if (i <= 5) chk("R2 decrement", count, 16'(5 - i));
            chk("R4 event timing", evt, (i == 5));
            if (i == 6) chk("R3 all-ones", count, 16'hFFFF);
            if (i == 7) chk("R3 reload", count, 16'h0005);
        end
        run_ticks(14, e);
        chk("R3 two periods events", e, 2);
        chk("R3 two periods count", count, 16'h0005);
    endtask

    task automatic t_hi_latch();
        logic [7:0] v;
        int e;
        run_ticks(2, e);
        chk("R2 count", count, 16'h0003);
        step(1'b0, 1'b1, 1'b0, 2'd3, 8'h01);
        chk("R8 count kept", count, 16'h0003);
        chk("R8 clr", clr, 1'b1);
        peek(2'd3, v); chk("R9 latch hi read", v, 8'h01);
        run_ticks(3, e);
        chk("R4 event at zero", e, 1);
        chk("R4 zero", count, 16'h0000);
        run_ticks(2, e);
        chk("R8 new latch reload", count, 16'h0105);
    endtask

    task automatic t_reads();
        logic [7:0] v;
        peek(2'd0, v); chk("R9 count lo", v, 8'h05);
        peek(2'd1, v); chk("R9 count hi", v, 8'h01);
        step(1'b0, 1'b0, 1'b1, 2'd0, 8'h00);
        chk("R9 lo read clears", clr, 1'b1);
        step(1'b0, 1'b0, 1'b1, 2'd1, 8'h00);
        chk("R9 hi read no clear", clr, 1'b0);
        step(1'b0, 1'b0, 1'b1, 2'd3, 8'h00);
        chk("R9 latch read no clear", clr, 1'b0);
        step(1'b0, 1'b1, 1'b0, 2'd0, 8'h20);
        chk("R6 slot0 count kept", count, 16'h0105);
        chk("R6 slot0 no clr", clr, 1'b0);
        peek(2'd2, v); chk("R6 latch lo", v, 8'h20);
        peek(2'd3, v); chk("R6 latch hi kept", v, 8'h01);
    endtask

    task automatic t_collision();
        int e;
        load5();
        run_ticks(4, e);
        chk("R2 count one", count, 16'h0001);
        step(1'b1, 1'b1, 1'b0, 2'd1, 8'h00);
        chk("R10 load wins", count, 16'h0005);
        chk("R10 no event", evt, 1'b0);
        chk("R10 clr", clr, 1'b1);
    endtask

    task automatic t_modes();
        int e;
        logic [1:0] ms [3];
        ms[0] = 2'b00; ms[1] = 2'b10; ms[2] = 2'b11;
        for (int k = 0; k < 3; k++) begin
            mode = ms[k];
            load5();
            run_ticks(14, e);
            chk("R5 no events", e, 0);
            chk("R5 still counts", count, 16'h0005);
        end
        mode = 2'b01;
    endtask

    task automatic t_reload_write();
        int e;
        load5();
        run_ticks(6, e);
        chk("R3 at all-ones", count, 16'hFFFF);
        step(1'b1, 1'b1, 1'b0, 2'd2, 8'h09);
        chk("R3 same-edge latch", count, 16'h0009);
    endtask

    task automatic t_zero_latch();
        int e;
        step(1'b0, 1'b1, 1'b0, 2'd2, 8'h00);
        step(1'b0, 1'b1, 1'b0, 2'd1, 8'h00);
        chk("R7 load zero", count, 16'h0000);
        chk("R10 load gives no event", evt, 1'b0);
        run_ticks(6, e);
        chk("R4 zero latch events", e, 3);
        chk("R4 zero latch count", count, 16'h0000);
    endtask

    initial begin
        #1000000;
        n_chk++;
        n_err++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;
        t_reset();
        t_period();
        t_hi_latch();
        t_reads();
        t_collision();
        t_modes();
        t_reload_write();
        t_zero_latch();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule